// File: doc/BRIEF.md
# Weighted Cyclic Upstream Merger

This block schedules the upward path of one node in a tree that runs an all-to-all exchange. The node has its own outgoing stream and up to four child streams that arrive from below. The block folds all of them into one stream toward the parent. It works in rounds. A round opens with one unit from the node's own stream. Each enabled child then supplies a burst whose length equals the size of that child's subtree. The children take their turns in ascending index order, and then the round starts again.

Every source and the sink use a valid/ready handshake. The block adds no storage of its own: the selected source is wired straight through to the output. The block does not reorder units. When the source whose turn it is has nothing to send, or the output cannot accept a unit, the block waits on that source.

A root configuration removes the local slot, so that only the children's data reaches the output, which then feeds the node's own input queue. A second mode, skip-empty polling, visits the sources in the same cyclic order. In that mode it moves at most one unit per visit and passes over any source that is empty.

Top module: `updraft_merger`

## Requirements
- R1: After the synchronous active-low reset is released, the first position served is the local slot: with `up_ready` high and every source valid, `own_ready` is high, every `kid_ready` bit is low, and `up_data` equals `own_data`.
- R2: In strict mode (`cfg_skip`=0) the output carries, round after round, one local unit followed by the bursts of the enabled children in increasing child index.
- R3: The burst length of child k is the 8-bit weight in `cfg_weight[8k+7:8k]`. A slot that has started keeps its source until that many units have moved.
- R4: In strict mode, if the current source is not valid or `up_ready` is low, no unit moves and the position does not change. While the current source is empty, `up_valid` is low and no other source receives ready.
- R5: At most one ready output is high in any cycle, and no ready output is high while `up_ready` is low.
- R6: Child k is left out of the round when `cfg_mask[k]` is 0 or its weight is 0. Its ready stays low and its queue is never drained.
- R7: With `cfg_root`=1 there is no local slot: `own_ready` never rises and the output carries only child bursts.
- R8: With `cfg_skip`=1 each visit moves at most one unit, and a source with no valid data is passed over in favour of the next enabled source in cyclic order.
- R9: A unit leaves on `up_data` unchanged from the source that receives the handshake.
- R10: With all children disabled and `cfg_root`=0, the output is the local stream alone, one unit per round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_weight | input | 32 | Per-child burst length, 8 bits per child, child k at bits 8k+7:8k |
| cfg_mask | input | 4 | Child enable, bit k for child k |
| cfg_root | input | 1 | 1 removes the local slot (tree root) |
| cfg_skip | input | 1 | 1 selects skip-empty polling, one unit per visit |
| own_valid | input | 1 | Local source has a unit |
| own_data | input | 32 | Local source unit |
| own_ready | output | 1 | Local unit taken this cycle when valid |
| kid_valid | input | 4 | Child source k has a unit |
| kid_data | input | 128 | Child units, child k at bits 32k+31:32k |
| kid_ready | output | 4 | Child k unit taken this cycle when valid |
| up_valid | output | 1 | Output carries a unit |
| up_data | output | 32 | Output unit |
| up_ready | input | 1 | Sink accepts a unit |

## Verification
The case that is hardest to reach from the ports is a stall in the middle of a round. The block must sit on a child whose queue is empty while the local source and the other children still hold data and the sink is ready. That state tests whether the block waits or jumps ahead. The bench builds it by loading every queue but hiding one child's contents behind a visibility limit. Once the stream stops at that child, the bench inspects the handshake lines, then reveals the queue and confirms that the rest of the stream keeps its exact order. Random source and sink back-pressure then recheck the ordering at many other stall points.

// File: rtl/updraft_pkg.sv
package updraft_pkg;

    // Polling discipline selected by the configuration bit.
    typedef enum logic {
        POLL_STRICT = 1'b0,
        POLL_SKIP   = 1'b1
    } poll_mode_e;

    // Slot number reserved for the node's own outgoing stream.
    localparam int LOCAL_SLOT = 0;

endpackage

// File: rtl/updraft_ring.sv
// updraft_ring
// Decides which slots take part in a round and finds the next slot after
// the current one in cyclic order. Slot 0 is the local stream and slot k+1
// is child k. The module is purely combinational.
// Assumes cur_slot never exceeds NC.
module updraft_ring #(
    parameter int NC     = 4,
    parameter int WW     = 8,
    parameter int SLOT_W = 3
) (
    input  logic [NC*WW-1:0]  cfg_weight,
    input  logic [NC-1:0]     cfg_mask,
    input  logic              cfg_root,
    input  logic [SLOT_W-1:0] cur_slot,
    output logic              cur_ok,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic [WW-1:0]     nxt_quota
);
    localparam int SPAN = 1 << SLOT_W;

    logic [SPAN-1:0] elig;
    logic [WW-1:0]   quota [SPAN];

    // The local slot takes part unless this node is the root, and it always moves one unit.
    assign elig[0]  = !cfg_root;
    assign quota[0] = WW'(1);

    // A child takes part when it is enabled and its weight is non-zero.
    for (genvar k = 0; k < NC; k++) begin : g_child
        logic [WW-1:0] w;
        assign w            = cfg_weight[k*WW +: WW];
        assign elig[k+1]    = cfg_mask[k] & (|w);
        assign quota[k+1]   = (|w) ? w : WW'(1);
    end

    // Slot numbers above NC are never eligible.
    for (genvar u = NC + 1; u < SPAN; u++) begin : g_pad
        assign elig[u]  = 1'b0;
        assign quota[u] = WW'(1);
    end

    // Search forward from the current slot for the first eligible slot.
    always_comb begin
        logic found;
        found    = 1'b0;
        nxt_slot = cur_slot;
        for (int i = 1; i <= NC + 1; i++) begin
            int c;
            c = int'(cur_slot) + i;
            if (c > NC) c = c - (NC + 1);
            if (!found && elig[c]) begin
                found    = 1'b1;
                nxt_slot = SLOT_W'(c);
            end
        end
    end

    assign cur_ok    = elig[cur_slot];
    assign nxt_quota = quota[nxt_slot];

endmodule

// File: rtl/updraft_sched.sv
// updraft_sched
// Holds the round position (slot register) and the count of units still
// owed by the current slot. Strict mode advances only after a slot's quota
// has moved. Skip mode advances after each unit and passes over an empty source.
// Assumes the configuration changes only while the block is idle.
module updraft_sched
    import updraft_pkg::*;
#(
    parameter int NC     = 4,
    parameter int WW     = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_skip,
    input  logic              cur_ok,
    input  logic              src_valid,
    input  logic              fire,
    input  logic [SLOT_W-1:0] nxt_slot,
    input  logic [WW-1:0]     nxt_quota,
    output logic [SLOT_W-1:0] slot_q
);
    logic [WW-1:0]     cnt_q, cnt_d;
    logic [SLOT_W-1:0] slot_d;
    logic              adv;
    poll_mode_e        mode;

    assign mode = poll_mode_e'(cfg_skip);

    // Decide whether to move to the next slot and what count to load.
    always_comb begin
        adv = 1'b0;
        if (!cur_ok)
            adv = 1'b1;
        else if (fire && (mode == POLL_SKIP || cnt_q <= WW'(1)))
            adv = 1'b1;
        else if (mode == POLL_SKIP && !src_valid)
            adv = 1'b1;

        slot_d = adv ? nxt_slot : slot_q;

        if (adv)
            cnt_d = (mode == POLL_SKIP) ? WW'(1) : nxt_quota;
        else if (fire)
            cnt_d = cnt_q - WW'(1);
        else
            cnt_d = cnt_q;
    end

    // Position and remaining count registers; reset returns to the local slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_W'(LOCAL_SLOT);
            cnt_q  <= WW'(1);
        end else begin
            slot_q <= slot_d;
            cnt_q  <= cnt_d;
        end
    end

    // R3
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    // R2
    quota_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ok && fire && mode == POLL_STRICT && cnt_q > WW'(1)) |=> $stable(slot_q));

endmodule

// File: rtl/updraft_xbar.sv
// updraft_xbar
// Steers the selected source to the output and returns the sink's ready
// to that source alone. There is no storage, so the path is combinational.
// Assumes slot never exceeds NC.
module updraft_xbar #(
    parameter int NC     = 4,
    parameter int DW     = 32,
    parameter int SLOT_W = 3
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              go,
    input  logic              own_valid,
    input  logic [DW-1:0]     own_data,
    input  logic [NC-1:0]     kid_valid,
    input  logic [NC*DW-1:0]  kid_data,
    output logic              src_valid,
    output logic [DW-1:0]     out_data,
    output logic              own_ready,
    output logic [NC-1:0]     kid_ready
);
    localparam int SPAN = 1 << SLOT_W;

    logic [SPAN-1:0] v_ext;
    logic [DW-1:0]   d_ext [SPAN];

    // Local source occupies slot 0.
    assign v_ext[0]  = own_valid;
    assign d_ext[0]  = own_data;
    assign own_ready = go && (slot == SLOT_W'(0));

    // Child k occupies slot k+1.
    for (genvar k = 0; k < NC; k++) begin : g_kid
        assign v_ext[k+1]   = kid_valid[k];
        assign d_ext[k+1]   = kid_data[k*DW +: DW];
        assign kid_ready[k] = go && (slot == SLOT_W'(k + 1));
    end

    // Slot numbers above NC carry nothing.
    for (genvar u = NC + 1; u < SPAN; u++) begin : g_pad
        assign v_ext[u] = 1'b0;
        assign d_ext[u] = '0;
    end

    assign src_valid = v_ext[slot];
    assign out_data  = d_ext[slot];

endmodule

// File: rtl/updraft_merger.sv
// updraft_merger
// Merges the node's own stream and up to NC child streams into one upward
// stream. A round is one local unit followed by a weighted burst from each
// enabled child in index order. The selected source passes straight through.
// Assumes configuration inputs are held steady while traffic moves.
module updraft_merger #(
    parameter int NC = 4,
    parameter int DW = 32,
    parameter int WW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC*WW-1:0] cfg_weight,
    input  logic [NC-1:0]    cfg_mask,
    input  logic             cfg_root,
    input  logic             cfg_skip,
    input  logic             own_valid,
    input  logic [DW-1:0]    own_data,
    output logic             own_ready,
    input  logic [NC-1:0]    kid_valid,
    input  logic [NC*DW-1:0] kid_data,
    output logic [NC-1:0]    kid_ready,
    output logic             up_valid,
    output logic [DW-1:0]    up_data,
    input  logic             up_ready
);
    localparam int SLOT_W = $clog2(NC + 1);

    logic [SLOT_W-1:0] slot_q, nxt_slot;
    logic [WW-1:0]     nxt_quota;
    logic              cur_ok, src_valid, go, fire;

    updraft_ring #(.NC(NC), .WW(WW), .SLOT_W(SLOT_W)) u_ring (
        .cfg_weight (cfg_weight),
        .cfg_mask   (cfg_mask),
        .cfg_root   (cfg_root),
        .cur_slot   (slot_q),
        .cur_ok     (cur_ok),
        .nxt_slot   (nxt_slot),
        .nxt_quota  (nxt_quota)
    );

    updraft_xbar #(.NC(NC), .DW(DW), .SLOT_W(SLOT_W)) u_xbar (
        .slot      (slot_q),
        .go        (go),
        .own_valid (own_valid),
        .own_data  (own_data),
        .kid_valid (kid_valid),
        .kid_data  (kid_data),
        .src_valid (src_valid),
        .out_data  (up_data),
        .own_ready (own_ready),
        .kid_ready (kid_ready)
    );

    updraft_sched #(.NC(NC), .WW(WW), .SLOT_W(SLOT_W)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_skip  (cfg_skip),
        .cur_ok    (cur_ok),
        .src_valid (src_valid),
        .fire      (fire),
        .nxt_slot  (nxt_slot),
        .nxt_quota (nxt_quota),
        .slot_q    (slot_q)
    );

    // Handshake glue: output valid and grant only while the current slot takes part.
    assign up_valid = cur_ok && src_valid;
    assign go       = cur_ok && up_ready;
    assign fire     = up_valid && up_ready;

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kid_ready, own_ready}));

    // R5
    ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ready |-> !(own_ready || (|kid_ready)));

    // R7
    root_no_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_root |-> !own_ready);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ok && !fire && !cfg_skip) |=> $stable(slot_q));

    // R9
    local_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && own_ready) |-> (up_data == own_data));

endmodule

// File: tb/sim_updraft_merger.sv
module sim_updraft_merger;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NC = 4, DW = 32, WW = 8, NS = NC + 1, DEPTH = 128;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NC*WW-1:0] cfg_weight;
    logic [NC-1:0]    cfg_mask;
    logic             cfg_root, cfg_skip;
    logic             own_valid, own_ready;
    logic [DW-1:0]    own_data;
    logic [NC-1:0]    kid_valid, kid_ready;
    logic [NC*DW-1:0] kid_data;
    logic             up_valid, up_ready;
    logic [DW-1:0]    up_data;

    always #2.5 clk = ~clk;

    updraft_merger #(.NC(NC), .DW(DW), .WW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_weight(cfg_weight), .cfg_mask(cfg_mask),
        .cfg_root(cfg_root), .cfg_skip(cfg_skip),
        .own_valid(own_valid), .own_data(own_data), .own_ready(own_ready),
        .kid_valid(kid_valid), .kid_data(kid_data), .kid_ready(kid_ready),
        .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready)
    );

    // Bench-side source queues, expected stream, and bookkeeping.
    logic [DW-1:0] mem [NS][DEPTH];
    int            head [NS];
    int            tail [NS];
    int            lim  [NS];
    logic [DW-1:0] expq [$];
    int            wt   [NC];
    bit            stall_src, stall_up, root_watch, done;
    int            checks, fails;

    function automatic logic [DW-1:0] tagof(int s, int n);
        return {8'(s), 24'(n)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Store one item in source s; optionally add it to the expected stream.
    task automatic put(int s, bit expect_it);
        logic [DW-1:0] item;
        item = tagof(s, tail[s]);
        mem[s][tail[s]] = item;
        tail[s]++;
        lim[s] = tail[s];
        if (expect_it) expq.push_back(item);
    endtask

    task automatic clear_all();
        for (int s = 0; s < NS; s++) begin
            head[s] = 0; tail[s] = 0; lim[s] = 0;
        end
        expq.delete();
        stall_src = 0; stall_up = 0; root_watch = 0;
    endtask

    task automatic setcfg(int w0, int w1, int w2, int w3, logic [NC-1:0] m, bit root, bit skip);
        wt[0] = w0; wt[1] = w1; wt[2] = w2; wt[3] = w3;
        for (int k = 0; k < NC; k++) cfg_weight[k*WW +: WW] = WW'(wt[k]);
        cfg_mask = m; cfg_root = root; cfg_skip = skip;
    endtask

    // Driver: load sources and expected stream for strict-mode rounds (R2, R3).
    task automatic fill_rounds(int rounds);
        for (int r = 0; r < rounds; r++) begin
            if (!cfg_root) put(0, 1);
            for (int k = 0; k < NC; k++)
                if (cfg_mask[k] && wt[k] != 0)
                    for (int j = 0; j < wt[k]; j++) put(k + 1, 1);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain(string req);
        int n;
        n = 0;
        while (expq.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, req, "expected stream fully delivered", DW'(expq.size()), '0);
    endtask

    // Drive source valid/data and sink ready at each falling edge.
    always @(negedge clk) begin
        for (int s = 0; s < NS; s++) begin
            bit v;
            logic [DW-1:0] d;
            v = (head[s] < lim[s]) && (!stall_src || $urandom_range(0, 3) != 0);
            d = (head[s] < DEPTH) ? mem[s][head[s]] : '0;
            if (s == 0) begin
                own_valid = v; own_data = d;
            end else begin
                kid_valid[s-1] = v; kid_data[(s-1)*DW +: DW] = d;
            end
        end
        up_ready = !stall_up || ($urandom_range(0, 2) != 0);
    end

    // Monitor: pop and compare each unit that leaves the block.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            int n;
            n = int'(own_ready) + $countones(kid_ready);
            // R5: single grant, none without sink ready
            if (n > 1 || (!up_ready && n != 0))
                chk(0, "R5", "grant count", DW'(n), DW'(up_ready));
            // R7: local ready never in root mode
            if (root_watch && own_ready)
                chk(0, "R7", "own_ready in root mode", 1, 0);
            if (up_valid && up_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R2", "unexpected unit", up_data, '0);
                end else begin
                    logic [DW-1:0] e;
                    e = expq.pop_front();
                    // R2 order and R9 unchanged payload
                    chk(up_data == e, "R2 R9", "unit order/payload", up_data, e);
                end
                if (own_valid && own_ready) head[0]++;
                for (int k = 0; k < NC; k++)
                    if (kid_valid[k] && kid_ready[k]) head[k+1]++;
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #900000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        checks = 0; fails = 0; done = 0;
        rst_n = 1'b0;
        clear_all();
        setcfg(0, 0, 0, 0, '0, 0, 0);

        // Test A: basic weighted rounds, reset state
        clear_all();
        setcfg(3, 1, 2, 4, 4'b1111, 0, 0);
        fill_rounds(4);
        reset_dut();
        #2;
        // R1
        chk(own_ready == 1'b1, "R1", "own_ready after reset", DW'(own_ready), 1);
        chk(kid_ready == '0, "R1", "kid_ready after reset", DW'(kid_ready), 0);
        chk(up_valid && up_data == tagof(0, 0), "R1", "first unit is local", up_data, tagof(0, 0));
        drain("R3");

        // Test B: random back-pressure on sources and sink (R4)
        clear_all();
        setcfg(2, 3, 1, 2, 4'b1111, 0, 0);
        fill_rounds(6);
        stall_src = 1; stall_up = 1;
        reset_dut();
        drain("R4");

        // Test C: masked child and zero-weight child are left out (R6)
        clear_all();
        setcfg(2, 0, 3, 1, 4'b1011, 0, 0);
        fill_rounds(3);
        for (int j = 0; j < 3; j++) put(2, 0);
        for (int j = 0; j < 2; j++) put(3, 0);
        reset_dut();
        drain("R6");
        chk(head[2] == 0, "R6", "zero-weight child untouched", DW'(head[2]), 0);
        chk(head[3] == 0, "R6", "masked child untouched", DW'(head[3]), 0);

        // Test D: root mode, no local slot (R7)
        clear_all();
        setcfg(1, 2, 1, 1, 4'b1111, 1, 0);
        for (int j = 0; j < 3; j++) put(0, 0);
        fill_rounds(3);
        root_watch = 1;
        reset_dut();
        drain("R7");
        chk(head[0] == 0, "R7", "local queue untouched at root", DW'(head[0]), 0);
        root_watch = 0;

        // Test E: all children disabled gives local-only stream (R10)
        clear_all();
        setcfg(1, 1, 1, 1, 4'b0000, 0, 0);
        fill_rounds(5);
        reset_dut();
        drain("R10");
        chk(head[0] == 5, "R10", "local units sent", DW'(head[0]), 5);

        // Test F: stall on an empty child while others hold data (R4)
        clear_all();
        setcfg(1, 1, 1, 1, 4'b1111, 0, 0);
        fill_rounds(3);
        lim[2] = 0;
        reset_dut();
        repeat (12) @(negedge clk);
        #2;
        chk(up_valid == 1'b0, "R4", "no output while child1 empty", DW'(up_valid), 0);
        chk(kid_ready == 4'b0010, "R4", "ready held on child1 only", DW'(kid_ready), 4'b0010);
        chk(own_ready == 1'b0, "R4", "local not served during hold", DW'(own_ready), 0);
        chk(head[0] == 1 && head[1] == 1, "R4", "units moved before hold",
            DW'(head[0] + head[1]), 2);
        lim[2] = tail[2];
        drain("R4");

        // Test G: skip-empty polling, one unit per visit (R8)
        clear_all();
        setcfg(5, 5, 5, 5, 4'b1111, 0, 1);
        for (int j = 0; j < 2; j++) put(0, 0);
        for (int j = 0; j < 3; j++) put(2, 0);
        put(4, 0);
        begin
            int rem [NS];
            int took [NS];
            int left;
            for (int s = 0; s < NS; s++) begin rem[s] = tail[s]; took[s] = 0; end
            left = 6;
            while (left > 0) begin
                for (int s = 0; s < NS; s++)
                    if (rem[s] > 0) begin
                        expq.push_back(tagof(s, took[s]));
                        took[s]++; rem[s]--; left--;
                    end
            end
        end
        reset_dut();
        drain("R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule